// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Array

This block decides, for every identifier that a CAN receiver hands it, whether the frame is kept. If the frame is kept, the block also reports which of two receive queues the frame goes to and which filter matched it. The block holds a parameterised array of filter banks, 14 by default. Each bank carries two 32-bit compare registers. The bank is set up as either a masked compare or an exact identifier list, and it works either on the full 32-bit identifier word or on two 16-bit half-words. So one bank gives one, two or four filters.

The receiver presents the identifier as separate fields: the 11-bit base part, the 18-bit extension, the extended-format flag and the remote-request flag. It pulses a valid strobe with them. One clock later the block gives a registered verdict. Software programs the array through a simple write port. There is a global filter-setup flag. While the flag is set, the layout of the banks can be changed and no frame is accepted. While the flag is clear, only the enables and the values of inactive banks can change.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, res_valid, res_accept, res_fifo and res_index are 0, every bank is inactive, every bank is in 16-bit mask mode on queue 0, and the setup flag is clear.
- R2: Each cycle with id_valid high gives exactly one cycle of res_valid on the following clock edge. Back-to-back identifiers give back-to-back results in the same order. res_valid is never high without a preceding id_valid.
- R3: A bank whose bit is 0 in the enable register (address 4, bit b for bank b, writable at any time) never matches. Its filters still count toward the numbering of the filters after it.
- R4: In 32-bit mask mode, the identifier word is {base[10:0], ext[17:0], xflag, rtr, 1'b0}. Register 1 holds the compare value and register 2 the mask. A mask bit of 1 requires equality at that position, and a mask bit of 0 ignores that position.
- R5: In 32-bit list mode, the word must equal register 1 (filter 0 of the bank) or register 2 (filter 1 of the bank) exactly.
- R6: In 16-bit scale, the half-word is {base[10:0], rtr, xflag, ext[17:15]}, and ext[14:0] is ignored. In mask mode, each register holds the compare value in bits 15:0 and the mask in bits 31:16. This gives filter 0 from register 1 and filter 1 from register 2.
- R7: In 16-bit list mode, the four exact half-word filters are, in order, register 1 bits 15:0, register 1 bits 31:16, register 2 bits 15:0 and register 2 bits 31:16.
- R8: An accepted frame reports res_fifo equal to the queue bit of the matching bank (address 3, bit b).
- R9: Filters are numbered consecutively in bank order. A bank adds 1 (32-bit mask), 2 (32-bit list or 16-bit mask) or 4 (16-bit list) to the count. When several filters match, the lowest number wins, and res_index reports it.
- R10: While the setup flag (address 0, bit 0) is set, every identifier is rejected.
- R11: Writes to the mode register (address 1, bit b = 1 for list), the scale register (address 2, bit b = 1 for 32-bit) and the queue register (address 3) are ignored while the setup flag is clear.
- R12: A write to a compare register (bank b register 1 at address 8+2b, register 2 at address 9+2b) is ignored while that bank is active and the setup flag is clear.
- R13: res_accept is only high together with res_valid. When res_accept is low, res_fifo and res_index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (6) | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| id_valid | input | 1 | Identifier fields are valid this cycle |
| id_std | input | 11 | Base identifier |
| id_ext | input | 18 | Identifier extension |
| id_ide | input | 1 | Extended-format flag |
| id_rtr | input | 1 | Remote-request flag |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_fifo | output | 1 | Receive queue of accepted frame |
| res_index | output | IW (6) | Number of the winning filter |

## Verification
The hardest case to reach from the ports is an overlap between banks of different shapes. Here the winning number depends on how many filters every earlier bank contributes, including banks that are disabled. The stimulus builds a row of banks with every mode and scale combination, leaves a catch-all mask bank disabled after them, and first shows that this bank rejects frames. It then enables the bank and sends identifiers that hit both it and an earlier list or mask filter, so that the reported number shows both the prefix count and the lowest-number rule. The locking rules are exercised by writes made while the setup flag is clear, each followed by an identifier whose verdict would change if the write had taken effect.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  // configuration address map
  localparam int unsigned ADR_CTL   = 0;
  localparam int unsigned ADR_MODE  = 1;
  localparam int unsigned ADR_SCALE = 2;
  localparam int unsigned ADR_FIFO  = 3;
  localparam int unsigned ADR_ACT   = 4;
  localparam int unsigned ADR_BANK0 = 8;

  // full compare word: base, extension, xflag, rtr, zero
  function automatic logic [31:0] make_word(input logic [10:0] std_id,
                                            input logic [17:0] ext_id,
                                            input logic        ide,
                                            input logic        rtr);
    return {std_id, ext_id, ide, rtr, 1'b0};
  endfunction

  // half compare word derived from the full word
  function automatic logic [15:0] to_half(input logic [31:0] w);
    return {w[31:21], w[1], w[2], w[20:18]};
  endfunction

endpackage

// File: rtl/can_filt_rst.sv
module can_filt_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sn = s2_q;
endmodule

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int unsigned NB = 14,
  parameter int unsigned AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  output logic                 init_o,
  output logic [NB-1:0]        list_o,
  output logic [NB-1:0]        wide_o,
  output logic [NB-1:0]        fifo_o,
  output logic [NB-1:0]        act_o,
  output logic [NB-1:0][31:0]  fr1_o,
  output logic [NB-1:0][31:0]  fr2_o
);
  logic          init_q, init_d;
  logic [NB-1:0] list_q, list_d, wide_q, wide_d, fifo_q, fifo_d, act_q, act_d;
  logic          hit_ctl, hit_mode, hit_scale, hit_fifo, hit_act;
  logic [NB-1:0][31:0] fr1_q, fr2_q;
  logic [NB-1:0] wr1, wr2;

  // next state for the global registers
  always_comb begin
    hit_ctl   = we && (addr == AW'(ADR_CTL));
    hit_mode  = we && (addr == AW'(ADR_MODE))  && init_q;
    hit_scale = we && (addr == AW'(ADR_SCALE)) && init_q;
    hit_fifo  = we && (addr == AW'(ADR_FIFO))  && init_q;
    hit_act   = we && (addr == AW'(ADR_ACT));
    init_d = hit_ctl   ? wdata[0]      : init_q;
    list_d = hit_mode  ? wdata[NB-1:0] : list_q;
    wide_d = hit_scale ? wdata[NB-1:0] : wide_q;
    fifo_d = hit_fifo  ? wdata[NB-1:0] : fifo_q;
    act_d  = hit_act   ? wdata[NB-1:0] : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
      list_q <= '0;
      wide_q <= '0;
      fifo_q <= '0;
      act_q  <= '0;
    end else begin
      init_q <= init_d;
      list_q <= list_d;
      wide_q <= wide_d;
      fifo_q <= fifo_d;
      act_q  <= act_d;
    end
  end

  // per-bank compare registers, writable only when unlocked
  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int unsigned A1 = ADR_BANK0 + 2 * b;
    localparam int unsigned A2 = A1 + 1;

    always_comb begin
      wr1[b] = we && (addr == AW'(A1)) && (init_q || !act_q[b]);
      wr2[b] = we && (addr == AW'(A2)) && (init_q || !act_q[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fr1_q[b] <= '0;
        fr2_q[b] <= '0;
      end else begin
        if (wr1[b]) fr1_q[b] <= wdata;
        if (wr2[b]) fr2_q[b] <= wdata;
      end
    end
  end

  assign init_o = init_q;
  assign list_o = list_q;
  assign wide_o = wide_q;
  assign fifo_o = fifo_q;
  assign act_o  = act_q;
  assign fr1_o  = fr1_q;
  assign fr2_o  = fr2_q;
endmodule

// File: rtl/can_filt_bank.sv
module can_filt_bank
  import can_filt_pkg::*;
(
  input  logic [31:0] word,
  input  logic        list,
  input  logic        wide,
  input  logic        act,
  input  logic [31:0] fr1,
  input  logic [31:0] fr2,
  output logic [3:0]  hit,
  output logic [2:0]  nfilt
);
  logic [15:0] half;
  logic [3:0]  raw;

  always_comb begin
    half = to_half(word);
    raw  = '0;
    unique case ({wide, list})
      2'b11: begin
        raw[0] = (word == fr1);
        raw[1] = (word == fr2);
        nfilt  = 3'd2;
      end
      2'b10: begin
        raw[0] = ((word ^ fr1) & fr2) == '0;
        nfilt  = 3'd1;
      end
      2'b01: begin
        raw[0] = (half == fr1[15:0]);
        raw[1] = (half == fr1[31:16]);
        raw[2] = (half == fr2[15:0]);
        raw[3] = (half == fr2[31:16]);
        nfilt  = 3'd4;
      end
      default: begin
        raw[0] = ((half ^ fr1[15:0]) & fr1[31:16]) == '0;
        raw[1] = ((half ^ fr2[15:0]) & fr2[31:16]) == '0;
        nfilt  = 3'd2;
      end
    endcase
    hit = raw & {4{act}};
  end
endmodule

// File: rtl/can_filt_arb.sv
module can_filt_arb #(
  parameter int unsigned NB = 14,
  parameter int unsigned IW = 6,
  parameter int unsigned BW = 4
) (
  input  logic [NB-1:0][3:0] hit,
  input  logic [NB-1:0][2:0] nfilt,
  output logic               any,
  output logic [BW-1:0]      sel,
  output logic [IW-1:0]      idx
);
  logic [IW-1:0] base;
  logic [1:0]    loc;

  always_comb begin
    any  = 1'b0;
    sel  = '0;
    idx  = '0;
    base = '0;
    loc  = '0;
    for (int b = 0; b < NB; b++) begin
      if (!any && (hit[b] != '0)) begin
        any = 1'b1;
        sel = BW'(b);
        if      (hit[b][0]) loc = 2'd0;
        else if (hit[b][1]) loc = 2'd1;
        else if (hit[b][2]) loc = 2'd2;
        else                loc = 2'd3;
        idx = base + IW'(loc);
      end
      base = base + IW'(nfilt[b]);
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 14,
  parameter int unsigned AW = $clog2(ADR_BANK0 + 2 * NUM_BANKS),
  parameter int unsigned IW = $clog2(4 * NUM_BANKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          id_valid,
  input  logic [10:0]   id_std,
  input  logic [17:0]   id_ext,
  input  logic          id_ide,
  input  logic          id_rtr,
  output logic          res_valid,
  output logic          res_accept,
  output logic          res_fifo,
  output logic [IW-1:0] res_index
);
  localparam int unsigned BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic                       rst_s;
  logic                       init;
  logic [NUM_BANKS-1:0]       list, wide, fifo, act;
  logic [NUM_BANKS-1:0][31:0] fr1, fr2;
  logic [NUM_BANKS-1:0][3:0]  hit;
  logic [NUM_BANKS-1:0][2:0]  nfilt;
  logic [31:0]                word;
  logic                       any;
  logic [BW-1:0]              sel;
  logic [IW-1:0]              idx;

  logic          valid_q, valid_d, acc_q, acc_d, fifo_q, fifo_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          res_en;

  can_filt_rst u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_s));

  can_filt_cfg #(.NB(NUM_BANKS), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_s), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .init_o(init), .list_o(list), .wide_o(wide), .fifo_o(fifo), .act_o(act),
    .fr1_o(fr1), .fr2_o(fr2)
  );

  assign word = make_word(id_std, id_ext, id_ide, id_rtr);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flt
    can_filt_bank u_bank (
      .word(word), .list(list[b]), .wide(wide[b]), .act(act[b]),
      .fr1(fr1[b]), .fr2(fr2[b]), .hit(hit[b]), .nfilt(nfilt[b])
    );
  end

  can_filt_arb #(.NB(NUM_BANKS), .IW(IW), .BW(BW)) u_arb (
    .hit(hit), .nfilt(nfilt), .any(any), .sel(sel), .idx(idx)
  );

  // next state of the verdict
  always_comb begin
    valid_d = id_valid;
    acc_d   = id_valid && !init && any;
    fifo_d  = acc_d ? fifo[sel] : 1'b0;
    idx_d   = acc_d ? idx : '0;
    res_en  = id_valid || valid_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
      fifo_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (res_en) begin
        acc_q  <= acc_d;
        fifo_q <= fifo_d;
        idx_q  <= idx_d;
      end
    end
  end

  assign res_valid  = valid_q;
  assign res_accept = acc_q;
  assign res_fifo   = fifo_q;
  assign res_index  = idx_q;
endmodule

// File: rtl/can_filt_chk.sv
module can_filt_chk
  import can_filt_pkg::*;
#(
  parameter int unsigned NB = 14,
  parameter int unsigned AW = 6,
  parameter int unsigned IW = 6
) (
  input logic          clk,
  input logic          rst_s,
  input logic          id_valid,
  input logic          init,
  input logic [NB-1:0] act,
  input logic [NB-1:0] list,
  input logic [NB-1:0] wide,
  input logic [NB-1:0] fifo,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_addr,
  input logic          res_valid,
  input logic          res_accept,
  input logic          res_fifo,
  input logic [IW-1:0] res_index
);
  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rst_s)
    id_valid |=> res_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_s)
    !id_valid |=> !res_valid);
  p_inactive_reject_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (id_valid && act == '0) |=> !res_accept);
  p_setup_reject_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (id_valid && init) |=> !res_accept);
  p_mode_locked_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_we && !init && cfg_addr == AW'(ADR_MODE)) |=> $stable(list));
  p_scale_locked_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_we && !init && cfg_addr == AW'(ADR_SCALE)) |=> $stable(wide));
  p_fifo_locked_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_we && !init && cfg_addr == AW'(ADR_FIFO)) |=> $stable(fifo));
  p_accept_needs_valid_r13: assert property (@(posedge clk) disable iff (!rst_s)
    res_accept |-> res_valid);
  p_quiet_reject_r13: assert property (@(posedge clk) disable iff (!rst_s)
    !res_accept |-> (!res_fifo && res_index == '0));
endmodule

bind can_accept_filter can_filt_chk #(.NB(NUM_BANKS), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_s(rst_s), .id_valid(id_valid), .init(init), .act(act),
  .list(list), .wide(wide), .fifo(fifo), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .res_valid(res_valid), .res_accept(res_accept), .res_fifo(res_fifo),
  .res_index(res_index)
);

// File: tb/test_can_accept_filter.sv
`timescale 1ns/1ps
module test_can_accept_filter;
  localparam int AW = 6;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          id_valid;
  logic [10:0]   id_std;
  logic [17:0]   id_ext;
  logic          id_ide, id_rtr;
  logic          res_valid, res_accept, res_fifo;
  logic [IW-1:0] res_index;

  int vectors = 0;
  int fails   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  can_accept_filter i_can_accept_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .id_valid(id_valid), .id_std(id_std),
    .id_ext(id_ext), .id_ide(id_ide), .id_rtr(id_rtr),
    .res_valid(res_valid), .res_accept(res_accept), .res_fifo(res_fifo),
    .res_index(res_index)
  );

  function automatic logic [31:0] w32(logic [10:0] s, logic [17:0] e, logic x, logic r);
    return {s, e, x, r, 1'b0};
  endfunction

  function automatic logic [15:0] h16(logic [10:0] s, logic [2:0] eh, logic x, logic r);
    return {s, r, x, eh};
  endfunction

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    id_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = AW'(a);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: one identifier per call, expected verdict into the scoreboard
  task automatic send(input logic [10:0] s, input logic [17:0] e, input logic x,
                      input logic r, input logic acc, input logic fq,
                      input int ix, input string tag);
    @(negedge clk);
    id_valid = 1'b1;
    id_std = s; id_ext = e; id_ide = x; id_rtr = r;
    exp_q.push_back({acc, fq, 6'(ix)});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      id_valid = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_q.size() == 0) begin
        vectors++;
        fails++;
        $display("FAIL R2 unexpected result: got acc=%0b idx=%0d, expected none",
                 res_accept, res_index);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if ({res_accept, res_fifo, res_index} !== e) begin
          fails++;
          $display("FAIL %s: got acc=%0b fifo=%0b idx=%0d, expected acc=%0b fifo=%0b idx=%0d",
                   t, res_accept, res_fifo, res_index, e[7], e[6], e[5:0]);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    id_valid = 1'b0; id_std = '0; id_ext = '0; id_ide = 1'b0; id_rtr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    vectors++;
    if ({res_valid, res_accept, res_fifo, res_index} !== 9'd0) begin
      fails++;
      $display("FAIL R1: got %b, expected 0", {res_valid, res_accept, res_fifo, res_index});
    end

    // layout under setup
    cfg_write(0, 32'd1);
    cfg_write(1, 32'b01010);            // list: banks 1,3
    cfg_write(2, 32'b10011);            // 32-bit: banks 0,1,4
    cfg_write(3, 32'b11010);            // queue 1: banks 1,3,4
    cfg_write(8,  w32(11'h123, 18'h0, 1'b0, 1'b0));
    cfg_write(9,  w32(11'h7F0, 18'h0, 1'b1, 1'b0));
    cfg_write(10, w32(11'h555, 18'h2AAAA, 1'b1, 1'b0));
    cfg_write(11, w32(11'h111, 18'h0, 1'b0, 1'b1));
    cfg_write(12, {16'hFFE8, h16(11'h200, 3'b000, 1'b0, 1'b0)});
    cfg_write(13, {16'hFFFF, h16(11'h300, 3'b101, 1'b1, 1'b0)});
    cfg_write(14, {h16(11'h051, 3'b0, 1'b0, 1'b1), h16(11'h050, 3'b0, 1'b0, 1'b0)});
    cfg_write(15, {h16(11'h053, 3'b0, 1'b0, 1'b0), h16(11'h052, 3'b0, 1'b0, 1'b0)});
    cfg_write(16, 32'h0);
    cfg_write(17, 32'h0);               // bank 4: catch-all mask
    cfg_write(4, 32'b01111);            // banks 0..3 active

    send(11'h12F, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R10 setup flag rejects");
    idle(2);
    cfg_write(0, 32'd0);

    send(11'h12F, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R4 32-bit mask hit");
    send(11'h12F, 18'h0, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R4/R13 masked xflag mismatch");
    send(11'h555, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 1, "R5 list entry 0, R8 queue");
    send(11'h111, 18'h0, 1'b0, 1'b1, 1'b1, 1'b1, 2, "R5 list entry 1");
    send(11'h111, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R5 list rtr mismatch");
    send(11'h200, 18'h3FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 3, "R6 16-bit mask don't-care");
    send(11'h300, {3'b101, 15'h1234}, 1'b1, 1'b0, 1'b1, 1'b0, 4, "R6 low ext ignored");
    send(11'h300, {3'b100, 15'h1234}, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R6 ext high mismatch");
    send(11'h051, 18'h0, 1'b0, 1'b1, 1'b1, 1'b1, 6, "R7 list half 1");
    send(11'h053, 18'h0, 1'b0, 1'b0, 1'b1, 1'b1, 8, "R7 list half 3");
    send(11'h050, 18'h0, 1'b0, 1'b0, 1'b1, 1'b1, 5, "R7 list half 0");
    send(11'h052, 18'h0, 1'b0, 1'b1, 1'b0, 1'b0, 0, "R7 list rtr mismatch");
    send(11'h7AB, 18'h0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R3 inactive bank no match");
    idle(2);

    // locked writes
    cfg_write(10, w32(11'h7AB, 18'h0, 1'b0, 1'b0));
    send(11'h555, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 1, "R12 active bank value kept");
    cfg_write(1, 32'h0);
    cfg_write(3, 32'h0);
    send(11'h051, 18'h0, 1'b0, 1'b1, 1'b1, 1'b1, 6, "R11 mode/queue write ignored");
    idle(2);

    // enable catch-all: numbering and priority
    cfg_write(4, 32'b11111);
    send(11'h7AB, 18'h0, 1'b0, 1'b0, 1'b1, 1'b1, 9, "R9 index after mixed banks");
    send(11'h12F, 18'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R9 lowest bank wins");
    send(11'h051, 18'h0, 1'b0, 1'b1, 1'b1, 1'b1, 6, "R9 list beats later mask");
    send(11'h6AA, 18'h1, 1'b1, 1'b1, 1'b1, 1'b1, 9, "R2 back-to-back");
    idle(4);

    vectors++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: got %0d pending results, expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule